// File: doc/BRIEF.md
# 64-bit Comparator Timer with Periodic Events

The block is a free-running 64-bit up-counter paired with a 64-bit comparator and one interrupt line. The counter advances once per clock while running. Whenever the comparator is armed and the counter has reached or passed the comparator value, an event flag is raised. If auto-increment is on, every event also pushes the comparator forward by a programmable step, so that events recur at a fixed interval without software reloading the comparator.

Software reaches the block through a flat 32-bit register port with an address, a write strobe, write data and read data. Each access takes a single cycle and read data is combinational. The 64-bit counter and comparator each appear as two 32-bit words. The two counter words are not latched together, so a carry can land between two reads. Software reads high, then low, then high again, and retries when the two high reads differ. The event flag is cleared by writing a one to it, and the interrupt output is the flag gated by an enable bit.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Reads of offset 0x1C and of any offset that is not a multiple of 4 return zero, and writes to them change nothing.
- R2: While control bit 0 (run) is set, the counter grows by one on every clock. While it is clear, the counter holds its value.
- R3: A write to offset 0x00 replaces bits 31:0 of the counter and a write to 0x04 replaces bits 63:32. A carry out of the low word reaches the high word, and the counter wraps from all ones to zero.
- R4: While control bit 1 (compare arm) is set and the unsigned 64-bit counter is greater than or equal to the comparator ({0x14, 0x10}), the event flag (status offset 0x0C, bit 0) is set at the next clock. While bit 1 is clear, no comparator or counter write sets the flag.
- R5: Writing a value with bit 0 set to offset 0x0C clears the event flag. Writing a value with bit 0 clear has no effect.
- R6: If the event condition holds in the same cycle as a clearing write, the flag stays set.
- R7: `irq` is high exactly while the event flag is set and control bit 2 (interrupt enable) is set.
- R8: With control bit 3 (auto-increment) set, every cycle in which the event condition holds adds the 32-bit step at offset 0x18 to the comparator. The addition is a 64-bit add that discards its carry.
- R9: Control (offset 0x08, bits 3:0), the step register and both comparator words read back what was last written. Control bits above bit 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe; the write lands at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt: event flag gated by interrupt enable |

## Verification
Read data is combinational, so a register write is visible on the cycle after the one in which it was driven. A change to the run bit alters the counter one cycle later still, because the increment uses the control value already stored. The event flag, and with it `irq`, is set on the edge that ends the first cycle in which the armed comparison holds. Arming the comparator therefore shows up in the status word two cycles after the arming write. Each auto-increment step is visible one cycle after the cycle that matched. The bench drives exactly one access per cycle and pushes expected values that were worked out against these latencies. The monitor samples shortly after each falling edge, when the inputs of that cycle are settled.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    // Number of word-aligned registers in the map
    localparam int unsigned NUM_REGS = 7;

    // Register index = byte offset / 4
    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_CMP_LO = 3'd4,
        SEL_CMP_HI = 3'd5,
        SEL_STEP   = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    // Control word; run sits in bit 0, auto_inc in bit 3
    typedef struct packed {
        logic auto_inc;
        logic irq_en;
        logic cmp_arm;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // Write strobes produced by the register decoder
    typedef struct packed {
        logic [1:0] cnt_half;   // [1] high word, [0] low word
        logic [1:0] cmp_half;
        logic       ctrl_wr;
        logic       step_wr;
        logic       stat_clr;
    } wr_strobe_t;

    function automatic reg_sel_e sel_from_offset(input logic [1:0] byte_lane,
                                                 input logic [2:0] word_idx,
                                                 input logic       in_range);
        if (byte_lane != 2'b00 || !in_range)
            return SEL_NONE;
        return reg_sel_e'(word_idx);
    endfunction

endpackage

// File: rtl/ctm_regs.sv
module ctm_regs
    import ctm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  cmp_q,
    input  logic              flag_q,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] step_q,
    output wr_strobe_t        strb,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] word;
    reg_sel_e          sel;

    assign word = addr >> 2;
    assign sel  = sel_from_offset(addr[1:0], word[2:0], word < ADDR_W'(NUM_REGS));

    always_comb begin
        strb.cnt_half = {we && sel == SEL_CNT_HI, we && sel == SEL_CNT_LO};
        strb.cmp_half = {we && sel == SEL_CMP_HI, we && sel == SEL_CMP_LO};
        strb.ctrl_wr  = we && sel == SEL_CTRL;
        strb.step_wr  = we && sel == SEL_STEP;
        strb.stat_clr = we && sel == SEL_STAT && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            step_q <= '0;
        end else begin
            if (strb.ctrl_wr)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (strb.step_wr)
                step_q <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_CNT_LO: rdata = cnt_q[DATA_W-1:0];
            SEL_CNT_HI: rdata = cnt_q[CNT_W-1:DATA_W];
            SEL_CTRL:   rdata = DATA_W'(ctrl_q);
            SEL_STAT:   rdata = DATA_W'(flag_q);
            SEL_CMP_LO: rdata = cmp_q[DATA_W-1:0];
            SEL_CMP_HI: rdata = cmp_q[CNT_W-1:DATA_W];
            SEL_STEP:   rdata = step_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [1:0]        wr_half,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q
);

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = run ? cnt_q + CNT_W'(1) : cnt_q;
        // A software write to one half overrides that half of the increment
        for (int h = 0; h < 2; h++) begin
            if (wr_half[h])
                cnt_nxt[h*DATA_W +: DATA_W] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/ctm_compare.sv
module ctm_compare #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              cmp_arm,
    input  logic              auto_inc,
    input  logic [DATA_W-1:0] step_q,
    input  logic [1:0]        wr_half,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_clr,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              flag_q,
    output logic              hit
);

    logic [CNT_W-1:0] cmp_nxt;
    logic [CNT_W-1:0] step_ext;

    assign step_ext = CNT_W'(step_q);
    assign hit      = cmp_arm && (cnt_q >= cmp_q);

    always_comb begin
        cmp_nxt = (hit && auto_inc) ? cmp_q + step_ext : cmp_q;
        for (int h = 0; h < 2; h++) begin
            if (wr_half[h])
                cmp_nxt[h*DATA_W +: DATA_W] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cmp_q  <= cmp_nxt;
            // A new event wins over a clear in the same cycle
            flag_q <= hit || (flag_q && !stat_clr);
        end
    end

endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
    import ctm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] step_q;
    wr_strobe_t        strb;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              flag_q;
    logic              hit;

    ctm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .flag_q (flag_q),
        .ctrl_q (ctrl_q),
        .step_q (step_q),
        .strb   (strb),
        .rdata  (bus_rdata)
    );

    ctm_counter #(.DATA_W(DATA_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .wr_half (strb.cnt_half),
        .wdata   (bus_wdata),
        .cnt_q   (cnt_q)
    );

    ctm_compare #(.DATA_W(DATA_W)) u_compare (
        .clk      (clk),
        .rst      (rst),
        .cnt_q    (cnt_q),
        .cmp_arm  (ctrl_q.cmp_arm),
        .auto_inc (ctrl_q.auto_inc),
        .step_q   (step_q),
        .wr_half  (strb.cmp_half),
        .wdata    (bus_wdata),
        .stat_clr (strb.stat_clr),
        .cmp_q    (cmp_q),
        .flag_q   (flag_q),
        .hit      (hit)
    );

    assign irq = flag_q && ctrl_q.irq_en;

endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [DATA_W-1:0] step,
    input logic              run,
    input logic              arm,
    input logic              ainc,
    input logic              flag,
    input logic              cnt_wr,
    input logic              cmp_wr,
    input logic              clr
);

    logic ge_now;
    assign ge_now = arm && (cnt >= cmp);

    // R2
    cnt_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(cnt_wr)) |-> (cnt == $past(cnt) + CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(cnt_wr)) |-> $stable(cnt));

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(ge_now));

    // R4
    flag_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !$rose(flag));

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(clr) && !$past(ge_now)) |-> !flag);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag) && !$past(clr)) |-> flag);

    // R8
    step_add_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ge_now && ainc) && !$past(cmp_wr))
            |-> (cmp == $past(cmp) + CNT_W'($past(step))));

endmodule

bind cmp_timer64 ctm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt_q),
    .cmp    (cmp_q),
    .step   (step_q),
    .run    (ctrl_q.run),
    .arm    (ctrl_q.cmp_arm),
    .ainc   (ctrl_q.auto_inc),
    .flag   (flag_q),
    .cnt_wr (|strb.cnt_half),
    .cmp_wr (|strb.cmp_half),
    .clr    (strb.stat_clr)
);

// File: tb/test_cmp_timer64.sv
module test_cmp_timer64;

    localparam logic [4:0] A_CNT_LO = 5'h00;
    localparam logic [4:0] A_CNT_HI = 5'h04;
    localparam logic [4:0] A_CTRL   = 5'h08;
    localparam logic [4:0] A_STAT   = 5'h0C;
    localparam logic [4:0] A_CMP_LO = 5'h10;
    localparam logic [4:0] A_CMP_HI = 5'h14;
    localparam logic [4:0] A_STEP   = 5'h18;
    localparam logic [4:0] A_HOLE   = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp_data;
        bit          chk_irq;
        logic        exp_irq;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    cmp_timer64 i_cmp_timer64 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic rd_irq(input logic [4:0] a, input logic [31:0] e,
                          input bit ci, input logic ei, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        it.exp_data = e;
        it.chk_irq  = ci;
        it.exp_irq  = ei;
        it.tag      = tag;
        sb_q.push_back(it);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        rd_irq(a, e, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compares each pushed expectation in the cycle it was issued
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                tests++;
                if (bus_rdata !== it.exp_data) begin
                    fails++;
                    $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.exp_data);
                end
                if (it.chk_irq) begin
                    tests++;
                    if (irq !== it.exp_irq) begin
                        fails++;
                        $display("FAIL %s: irq actual %b expected %b", it.tag, irq, it.exp_irq);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset values and the unmapped offset
        rd_irq(A_STAT, 32'h0, 1'b1, 1'b0, "R1 status/irq");
        rd(A_CTRL,   32'h0, "R1 ctrl");
        rd(A_CNT_LO, 32'h0, "R1 cnt lo");
        rd(A_CNT_HI, 32'h0, "R1 cnt hi");
        rd(A_CMP_LO, 32'h0, "R1 cmp lo");
        rd(A_CMP_HI, 32'h0, "R1 cmp hi");
        rd(A_STEP,   32'h0, "R1 step");
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd(A_HOLE, 32'h0, "R1 hole read");
        rd(A_CTRL, 32'h0, "R1 hole write ignored");
        wr(5'h09, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h0, "R1 misaligned write ignored");
        rd(A_CNT_LO, 32'h0, "R2 stopped after reset");

        // R9: readback
        wr(A_STEP, 32'h1234_5678);
        rd(A_STEP, 32'h1234_5678, "R9 step");
        wr(A_CTRL, 32'hFFFF_FFF0);
        rd(A_CTRL, 32'h0, "R9 ctrl upper bits");
        wr(A_CTRL, 32'h0000_000C);
        rd(A_CTRL, 32'h0000_000C, "R9 ctrl");
        wr(A_CTRL, 32'h0);

        // R3 preload, R2 run/hold, carry into high word
        wr(A_CNT_LO, 32'hFFFF_FFFE);
        wr(A_CNT_HI, 32'h0000_0005);
        rd(A_CNT_LO, 32'hFFFF_FFFE, "R3 preload lo");
        rd(A_CNT_HI, 32'h0000_0005, "R3 preload hi");
        rd(A_CNT_LO, 32'hFFFF_FFFE, "R2 hold while stopped");
        wr(A_CTRL, 32'h1);
        rd(A_CNT_LO, 32'hFFFF_FFFE, "R2 first cycle after run");
        rd(A_CNT_LO, 32'hFFFF_FFFF, "R2 increment");
        rd(A_CNT_HI, 32'h0000_0006, "R3 carry to high");
        rd(A_CNT_LO, 32'h0000_0001, "R2 increment after carry");
        wr(A_CTRL, 32'h0);
        rd(A_CNT_LO, 32'h0000_0003, "R2 last step after stop");
        rd(A_CNT_LO, 32'h0000_0003, "R2 hold after stop");

        // R3 wrap
        wr(A_CNT_HI, 32'hFFFF_FFFF);
        wr(A_CNT_LO, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        rd(A_CNT_HI, 32'hFFFF_FFFF, "R3 all ones");
        rd(A_CNT_HI, 32'h0, "R3 wrap hi");
        rd(A_CNT_LO, 32'h1, "R3 wrap lo");
        wr(A_CTRL, 32'h0);
        rd(A_CNT_LO, 32'h3, "R3 after wrap stop");

        // R4 greater-than, R7 gating, R6, R5
        wr(A_CNT_LO, 32'd100);
        wr(A_CNT_HI, 32'h0);
        wr(A_CMP_LO, 32'd50);
        wr(A_CMP_HI, 32'h0);
        rd(A_STAT, 32'h0, "R4 no event while disarmed");
        wr(A_CTRL, 32'h2);
        rd(A_STAT, 32'h0, "R4 flag not yet set");
        rd_irq(A_STAT, 32'h1, 1'b1, 1'b0, "R4 greater fires / R7 irq masked");
        wr(A_CTRL, 32'h6);
        rd_irq(A_STAT, 32'h1, 1'b1, 1'b1, "R7 irq enabled");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h1, "R6 event beats clear");
        wr(A_CTRL, 32'h4);
        wr(A_STAT, 32'h0);
        rd_irq(A_STAT, 32'h1, 1'b1, 1'b1, "R5 zero write ignored");
        wr(A_STAT, 32'h1);
        rd_irq(A_STAT, 32'h0, 1'b1, 1'b0, "R5 clear / R7 irq drops");

        // R4 below and equal
        wr(A_CMP_LO, 32'd101);
        wr(A_CTRL, 32'h2);
        rd(A_STAT, 32'h0, "R4 below");
        rd(A_STAT, 32'h0, "R4 below held");
        wr(A_CMP_LO, 32'd100);
        rd(A_STAT, 32'h0, "R4 equal pending");
        rd(A_STAT, 32'h1, "R4 equal fires");
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, "R5 clear");

        // R4 high word dominates
        wr(A_CMP_HI, 32'h1);
        wr(A_CMP_LO, 32'h0);
        wr(A_CTRL, 32'h2);
        rd(A_STAT, 32'h0, "R4 high word");
        rd(A_STAT, 32'h0, "R4 high word held");
        wr(A_CTRL, 32'h0);

        // R8 periodic events
        wr(A_CNT_LO, 32'h0);
        wr(A_CNT_HI, 32'h0);
        wr(A_CMP_HI, 32'h0);
        wr(A_CMP_LO, 32'd5);
        wr(A_STEP, 32'd10);
        wr(A_CTRL, 32'hF);
        rd(A_CMP_LO, 32'd5, "R8 initial compare");
        for (int i = 0; i < 5; i++) rd(A_STAT, 32'h0, "R8 before first event");
        rd_irq(A_STAT, 32'h1, 1'b1, 1'b1, "R8 first event");
        rd(A_CMP_LO, 32'd15, "R8 first step");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, "R8 cleared between events");
        rd(A_CMP_LO, 32'd15, "R8 compare steady");
        for (int i = 0; i < 5; i++) rd(A_STAT, 32'h0, "R8 before second event");
        rd_irq(A_STAT, 32'h1, 1'b1, 1'b1, "R8 second event");
        rd(A_CMP_LO, 32'd25, "R8 second step");
        wr(A_CTRL, 32'h0);
        rd(A_CNT_LO, 32'd19, "R2 count during periodic run");

        // R8 carry discarded
        wr(A_STAT, 32'h1);
        wr(A_CNT_LO, 32'hFFFF_FFFF);
        wr(A_CNT_HI, 32'hFFFF_FFFF);
        wr(A_CMP_LO, 32'hFFFF_FFF0);
        wr(A_CMP_HI, 32'hFFFF_FFFF);
        wr(A_STEP, 32'h20);
        wr(A_CTRL, 32'hA);
        rd(A_CMP_LO, 32'hFFFF_FFF0, "R8 before wrap");
        rd(A_CMP_HI, 32'h0, "R8 wrapped hi");
        wr(A_CTRL, 32'h0);
        rd(A_CMP_LO, 32'h50, "R8 steps per cycle");
        rd(A_CMP_HI, 32'h0, "R8 hi after steps");
        rd_irq(A_STAT, 32'h1, 1'b1, 1'b0, "R8 flag / R7 masked");

        @(negedge clk);
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule